// File: doc/BRIEF.md
# Calibration Command Decoder and Configuration Register File

This block sits behind a one-wire serial front end that delivers complete command/data byte pairs. It decodes each pair and updates a 152-bit configuration shadow. The shadow holds the bridge and temperature correction coefficients, the clipping limits, the customer identification bytes and a permanent lock field. The block also streams the whole configuration back out one byte at a time.

Programming is refused until a specific pair moves the block into command mode. In command mode, each coefficient opcode writes one field. Where a field is narrower than the data byte, the upper data bits are discarded. Once the lock field holds one of two codes, the block refuses every later write until reset, and it flags each refused or unknown pair with a one-cycle error pulse. Each accepted write produces a one-cycle pulse so that a downstream integrity unit can recompute its checksum.

Top module: `calcmd_top`

## Requirements
- R1: While reset is active and after reset, `cfg_q` is zero except bits 31:17 = 0x198, bits 53:46 = 0x80, bits 112:106 = 0x7F, bits 102:100 = 3'b111 and bits 12:11 = 2'b10. After reset, `cmd_mode`, `raw_mode`, `rd_valid`, `cfg_changed` and `cmd_err` are 0.
- R2: The pair command 0x50 / data 0x90 sets `cmd_mode`. It stays set until reset. Receiving the same pair again is accepted, changes nothing and raises no error.
- R3: Outside command mode, a program opcode, a raw-mode request or a read-out request leaves `cfg_q` unchanged and raises `cmd_err` for one cycle.
- R4: Command 0x80 writes data[6:0] to bits 31:25. Command 0x90 writes data[7:0] to bits 24:17. Together these form the 15-bit bridge gain.
- R5: Command 0xA0 writes data[5:0] to bits 45:40. Command 0xB0 writes data[7:0] to bits 39:32. Together these form the 14-bit bridge offset.
- R6: Each of these commands writes its field and leaves all other bits unchanged:
  - 0xC0 writes bits 53:46 (temperature gain).
  - 0xD0 writes bits 61:54 (temperature offset).
  - 0xE0 writes bits 84:77 (offset drift).
  - 0xF0 writes bits 76:69 (gain drift).
  - 0x60 writes bits 95:88 (second-order term).
  - 0x70 writes data[6:0] to bits 68:62 (temperature set-point).
- R7: Each of these commands writes its field:
  - 0x08 writes data[6:0] to bits 112:106 (upper clip).
  - 0x18 writes data[6:0] to bits 119:113 (lower clip).
  - 0x28, 0x38 and 0x48 write customer ID bytes 0, 1 and 2 at bits 127:120, 135:128 and 143:136.
  - 0x58 writes data[2:0] to bits 102:100 (diagnostic enables) and data[5:3] to bits 105:103 (lock field).
- R8: In command mode, command 0x40 sets `raw_mode` when data is 0x10 and clears it for any other data.
- R9: When bits 105:103 equal 3'b011 or 3'b110, every later program command is refused with a `cmd_err` pulse. `cfg_q` then stays constant until reset. Any other lock code does not block writes.
- R10: In command mode, command 0x00 streams 20 bytes on `rd_data`, beginning one cycle after the pair. Byte i is bits 8i+7:8i of {0xA5, `cfg_q`}, so the least significant byte comes first and the final byte is 0xA5. A byte advances only on `rd_valid` && `rd_ready`; while `rd_ready` is low, the byte and `rd_valid` hold.
- R11: Each accepted write raises `cfg_changed` for exactly the one cycle after the pair. An unknown opcode, or any pair received while a read-out stream is still active, leaves all state unchanged and raises `cmd_err` for that one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pair_valid | input | 1 | A command/data pair is present this cycle |
| pair_cmd | input | 8 | Command byte |
| pair_data | input | 8 | Data byte |
| rd_data | output | 8 | Current read-out byte |
| rd_valid | output | 1 | Read-out byte is valid |
| rd_ready | input | 1 | Consumer accepts the read-out byte |
| cfg_q | output | 152 | Configuration shadow contents |
| cmd_mode | output | 1 | Command mode has been entered |
| raw_mode | output | 1 | Raw measurement mode requested |
| cfg_changed | output | 1 | One-cycle pulse after an accepted write |
| cmd_err | output | 1 | One-cycle pulse after a refused or unknown pair |

## Verification
The bench builds the block with its default parameters: a 152-bit shadow and three customer ID bytes. With these defaults the full 20-byte read-out, including the constant trailer, is observable, and the lock field sits at the position its codes are checked in. Seeded random pairs over the whole opcode set are compared with a bench model of the shadow, both before and after command-mode entry. Directed cases cover:
- the field bits that are masked off;
- back-pressure and foreign pairs during a read-out;
- both locking codes, each after its own reset;
- a non-locking code that leaves writes enabled.

// File: rtl/calcmd_pkg.sv
package calcmd_pkg;
  localparam int CFG_W      = 152;
  localparam int ID_BYTES   = 3;
  localparam int OSEL_LSB   = 11;
  localparam int BGAIN_LSB  = 17;
  localparam int BOFS_LSB   = 32;
  localparam int TGAIN_LSB  = 46;
  localparam int TOFS_LSB   = 54;
  localparam int TSET_LSB   = 62;
  localparam int TCG_LSB    = 69;
  localparam int TCO_LSB    = 77;
  localparam int SOT_LSB    = 88;
  localparam int DIAG_LSB   = 100;
  localparam int LOCK_LSB   = 103;
  localparam int UCLIP_LSB  = 106;
  localparam int LCLIP_LSB  = 113;
  localparam int ID_LSB     = 120;
  localparam logic [7:0] TRAILER = 8'hA5;

  typedef struct packed {
    logic             en;
    logic [CFG_W-1:0] mask;
    logic [CFG_W-1:0] val;
  } cfg_wr_t;

  function automatic logic [CFG_W-1:0] cfg_default();
    logic [CFG_W-1:0] c;
    c = '0;
    c[BGAIN_LSB +: 15] = 15'h198;
    c[TGAIN_LSB +: 8]  = 8'h80;
    c[UCLIP_LSB +: 7]  = 7'h7F;
    c[DIAG_LSB +: 3]   = 3'b111;
    c[OSEL_LSB +: 2]   = 2'b10;
    return c;
  endfunction

  function automatic logic is_lock_code(input logic [2:0] code);
    return (code == 3'b011) || (code == 3'b110);
  endfunction
endpackage

// File: rtl/calcmd_decode.sv
module calcmd_decode
  import calcmd_pkg::*;
(
  input  logic [7:0] cmd,
  input  logic [7:0] data,
  output cfg_wr_t    wr
);
  function automatic cfg_wr_t fld(input int lsb, input int w, input logic [7:0] d);
    cfg_wr_t f;
    f.en   = 1'b1;
    f.mask = '0;
    f.val  = '0;
    for (int i = 0; i < 8; i++) begin
      if (i < w) begin
        f.mask[lsb+i] = 1'b1;
        f.val[lsb+i]  = d[i];
      end
    end
    return f;
  endfunction

  always_comb begin
    wr = '0;
    unique case (cmd)
      8'h80:   wr = fld(BGAIN_LSB + 8, 7, data);
      8'h90:   wr = fld(BGAIN_LSB, 8, data);
      8'hA0:   wr = fld(BOFS_LSB + 8, 6, data);
      8'hB0:   wr = fld(BOFS_LSB, 8, data);
      8'hC0:   wr = fld(TGAIN_LSB, 8, data);
      8'hD0:   wr = fld(TOFS_LSB, 8, data);
      8'hE0:   wr = fld(TCO_LSB, 8, data);
      8'hF0:   wr = fld(TCG_LSB, 8, data);
      8'h60:   wr = fld(SOT_LSB, 8, data);
      8'h70:   wr = fld(TSET_LSB, 7, data);
      8'h08:   wr = fld(UCLIP_LSB, 7, data);
      8'h18:   wr = fld(LCLIP_LSB, 7, data);
      8'h58:   wr = fld(DIAG_LSB, 6, data);
      default: wr = '0;
    endcase
    for (int k = 0; k < ID_BYTES; k++) begin
      if (cmd == 8'h28 + 8'(16 * k)) wr = fld(ID_LSB + 8 * k, 8, data);
    end
  end
endmodule

// File: rtl/calcmd_regs.sv
module calcmd_regs
  import calcmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_go,
  input  cfg_wr_t          wr,
  output logic [CFG_W-1:0] cfg_q,
  output logic             locked
);
  logic [CFG_W-1:0] cfg_d;

  assign locked = is_lock_code(cfg_q[LOCK_LSB +: 3]);

  always_comb begin
    cfg_d = cfg_q;
    if (wr_go) cfg_d = (cfg_q & ~wr.mask) | (wr.val & wr.mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= cfg_default();
    else        cfg_q <= cfg_d;
  end

  // R9
  lock_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable(cfg_q));
endmodule

// File: rtl/calcmd_stream.sv
module calcmd_stream
  import calcmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CFG_W-1:0] cfg,
  input  logic             ready,
  output logic [7:0]       data,
  output logic             valid
);
  localparam int NB = CFG_W / 8 + 1;
  localparam int CW = $clog2(NB + 1);

  logic [NB*8-1:0] sh_q, sh_d;
  logic [CW-1:0]   cnt_q, cnt_d;

  assign valid = (cnt_q != '0);
  assign data  = sh_q[7:0];

  always_comb begin
    sh_d  = sh_q;
    cnt_d = cnt_q;
    if (load) begin
      sh_d  = {TRAILER, cfg};
      cnt_d = CW'(NB);
    end else if (valid && ready) begin
      sh_d  = sh_q >> 8;
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
    end
  end

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> (valid && $stable(data)));
endmodule

// File: rtl/calcmd_top.sv
module calcmd_top
  import calcmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pair_valid,
  input  logic [7:0]       pair_cmd,
  input  logic [7:0]       pair_data,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [CFG_W-1:0] cfg_q,
  output logic             cmd_mode,
  output logic             raw_mode,
  output logic             cfg_changed,
  output logic             cmd_err
);
  logic [1:0] rst_sync_q;
  logic       rst_i_n;
  cfg_wr_t    wr;
  logic       locked, wr_go, load;
  logic       cmd_d, raw_d, chg_d, err_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  calcmd_decode i_dec (.cmd(pair_cmd), .data(pair_data), .wr(wr));

  calcmd_regs i_regs (
    .clk(clk), .rst_n(rst_i_n), .wr_go(wr_go), .wr(wr),
    .cfg_q(cfg_q), .locked(locked));

  calcmd_stream i_strm (
    .clk(clk), .rst_n(rst_i_n), .load(load), .cfg(cfg_q),
    .ready(rd_ready), .data(rd_data), .valid(rd_valid));

  always_comb begin
    cmd_d = cmd_mode;
    raw_d = raw_mode;
    chg_d = 1'b0;
    err_d = 1'b0;
    wr_go = 1'b0;
    load  = 1'b0;
    if (pair_valid) begin
      if (rd_valid) begin
        err_d = 1'b1;
      end else if (pair_cmd == 8'h50 && pair_data == 8'h90) begin
        cmd_d = 1'b1;
      end else if (pair_cmd == 8'h40) begin
        if (cmd_mode) raw_d = (pair_data == 8'h10);
        else          err_d = 1'b1;
      end else if (pair_cmd == 8'h00) begin
        if (cmd_mode) load  = 1'b1;
        else          err_d = 1'b1;
      end else if (wr.en && cmd_mode && !locked) begin
        wr_go = 1'b1;
        chg_d = 1'b1;
      end else begin
        err_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      cmd_mode    <= 1'b0;
      raw_mode    <= 1'b0;
      cfg_changed <= 1'b0;
      cmd_err     <= 1'b0;
    end else begin
      cmd_mode    <= cmd_d;
      raw_mode    <= raw_d;
      cfg_changed <= chg_d;
      cmd_err     <= err_d;
    end
  end

  // R11
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    !(cfg_changed && cmd_err));
  // R11
  change_flag_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    !$stable(cfg_q) |-> cfg_changed);
  // R2
  mode_sticky_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    cmd_mode |=> cmd_mode);
  // R8
  raw_needs_cmd_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    raw_mode |-> cmd_mode);
endmodule

// File: tb/test_calcmd_top.sv
module test_calcmd_top;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         pair_valid;
  logic [7:0]   pair_cmd, pair_data;
  logic [7:0]   rd_data;
  logic         rd_valid, rd_ready;
  logic [151:0] cfg_q;
  logic         cmd_mode, raw_mode, cfg_changed, cmd_err;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [151:0] m_cfg;
  bit           m_cmd, m_raw, m_busy;

  always #2 clk = ~clk;

  calcmd_top i_calcmd_top (
    .clk(clk), .rst_n(rst_n), .pair_valid(pair_valid), .pair_cmd(pair_cmd),
    .pair_data(pair_data), .rd_data(rd_data), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .cfg_q(cfg_q), .cmd_mode(cmd_mode),
    .raw_mode(raw_mode), .cfg_changed(cfg_changed), .cmd_err(cmd_err));

  function automatic logic [151:0] exp_default();
    logic [151:0] c = '0;
    c[31:17]   = 15'h198;
    c[53:46]   = 8'h80;
    c[112:106] = 7'h7F;
    c[102:100] = 3'b111;
    c[12:11]   = 2'b10;
    return c;
  endfunction

  function automatic bit m_locked();
    return (m_cfg[105:103] == 3'b011) || (m_cfg[105:103] == 3'b110);
  endfunction

  function automatic bit is_prog(input logic [7:0] c);
    case (c)
      8'h80, 8'h90, 8'hA0, 8'hB0, 8'hC0, 8'hD0, 8'hE0, 8'hF0, 8'h60, 8'h70,
      8'h08, 8'h18, 8'h28, 8'h38, 8'h48, 8'h58: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string req_of(input logic [7:0] c);
    if (m_busy) return "R11";
    if (c == 8'h50) return "R2";
    if (!m_cmd) return "R3";
    if (c == 8'h40) return "R8";
    if (c == 8'h00) return "R10";
    if (is_prog(c) && m_locked()) return "R9";
    case (c)
      8'h80, 8'h90: return "R4";
      8'hA0, 8'hB0: return "R5";
      8'hC0, 8'hD0, 8'hE0, 8'hF0, 8'h60, 8'h70: return "R6";
      8'h08, 8'h18, 8'h28, 8'h38, 8'h48, 8'h58: return "R7";
      default: return "R11";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [159:0] act, input logic [159:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic model(input logic [7:0] c, input logic [7:0] d,
                       output bit chg, output bit err);
    chg = 1'b0;
    err = 1'b0;
    if (m_busy) err = 1'b1;
    else if (c == 8'h50 && d == 8'h90) m_cmd = 1'b1;
    else if (c == 8'h40) begin
      if (m_cmd) m_raw = (d == 8'h10); else err = 1'b1;
    end else if (c == 8'h00) begin
      if (!m_cmd) err = 1'b1;
    end else if (is_prog(c)) begin
      if (!m_cmd || m_locked()) err = 1'b1;
      else begin
        chg = 1'b1;
        case (c)
          8'h80: m_cfg[31:25]   = d[6:0];
          8'h90: m_cfg[24:17]   = d;
          8'hA0: m_cfg[45:40]   = d[5:0];
          8'hB0: m_cfg[39:32]   = d;
          8'hC0: m_cfg[53:46]   = d;
          8'hD0: m_cfg[61:54]   = d;
          8'hE0: m_cfg[84:77]   = d;
          8'hF0: m_cfg[76:69]   = d;
          8'h60: m_cfg[95:88]   = d;
          8'h70: m_cfg[68:62]   = d[6:0];
          8'h08: m_cfg[112:106] = d[6:0];
          8'h18: m_cfg[119:113] = d[6:0];
          8'h28: m_cfg[127:120] = d;
          8'h38: m_cfg[135:128] = d;
          8'h48: m_cfg[143:136] = d;
          default: m_cfg[105:100] = d[5:0];
        endcase
      end
    end else err = 1'b1;
  endtask

  task automatic send(input logic [7:0] c, input logic [7:0] d);
    bit chg, err;
    string req;
    req = req_of(c);
    @(negedge clk);
    pair_valid = 1'b1;
    pair_cmd   = c;
    pair_data  = d;
    @(negedge clk);
    pair_valid = 1'b0;
    model(c, d, chg, err);
    check(cfg_q == m_cfg, req, $sformatf("cfg after %h/%h", c, d), 160'(cfg_q), 160'(m_cfg));
    check(cfg_changed == chg, req, "changed pulse", 160'(cfg_changed), 160'(chg));
    check(cmd_err == err, req, "error pulse", 160'(cmd_err), 160'(err));
    check(cmd_mode == m_cmd && raw_mode == m_raw, req, "mode flags",
          160'({cmd_mode, raw_mode}), 160'({m_cmd, m_raw}));
    @(negedge clk);
    check(!cfg_changed && !cmd_err, "R11", "pulse width", 160'({cfg_changed, cmd_err}), 160'(0));
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    m_cfg = exp_default();
    m_cmd = 1'b0;
    m_raw = 1'b0;
    m_busy = 1'b0;
    repeat (3) @(negedge clk);
    check(cfg_q == m_cfg, "R1", "reset config", 160'(cfg_q), 160'(m_cfg));
    check({cmd_mode, raw_mode, rd_valid, cfg_changed, cmd_err} == 5'b0, "R1", "reset flags",
          160'({cmd_mode, raw_mode, rd_valid, cfg_changed, cmd_err}), 160'(0));
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic read_out(input bit stall);
    logic [159:0] exp;
    exp = {8'hA5, m_cfg};
    rd_ready = 1'b0;
    send(8'h00, 8'h00);
    for (int i = 0; i < 20; i++) begin
      check(rd_valid && rd_data == exp[8*i +: 8], "R10", $sformatf("byte %0d", i),
            160'({rd_valid, rd_data}), 160'({1'b1, exp[8*i +: 8]}));
      if (stall && i == 3) begin
        @(negedge clk);
        check(rd_valid && rd_data == exp[8*i +: 8], "R10", "stalled byte",
              160'({rd_valid, rd_data}), 160'({1'b1, exp[8*i +: 8]}));
      end
      if (stall && i == 5) begin
        m_busy = 1'b1;
        send(8'hC0, 8'h3C);
        m_busy = 1'b0;
        check(rd_valid && rd_data == exp[8*i +: 8], "R11", "byte after foreign pair",
              160'({rd_valid, rd_data}), 160'({1'b1, exp[8*i +: 8]}));
      end
      rd_ready = 1'b1;
      @(negedge clk);
      rd_ready = 1'b0;
    end
    check(!rd_valid, "R10", "stream end", 160'(rd_valid), 160'(0));
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] ops [16] = '{8'h80, 8'h90, 8'hA0, 8'hB0, 8'hC0, 8'hD0, 8'hE0, 8'hF0,
                              8'h60, 8'h70, 8'h08, 8'h18, 8'h28, 8'h38, 8'h48, 8'h40};
    logic [7:0] c, d;
    void'($urandom(32'd4711));
    pair_valid = 1'b0;
    pair_cmd   = '0;
    pair_data  = '0;
    rd_ready   = 1'b0;
    do_reset();

    // R3: everything refused before command mode
    for (int n = 0; n < 20; n++) send(ops[$urandom_range(0, 15)], 8'($urandom));
    send(8'h00, 8'h00);
    send(8'h58, 8'h1B);
    send(8'h50, 8'h91);

    // R2: entry, then repeated entry
    send(8'h50, 8'h90);
    send(8'h50, 8'h90);

    // R4 R5 R6 R7: directed masking
    send(8'h80, 8'hFF);
    send(8'h90, 8'hA5);
    send(8'hA0, 8'hFF);
    send(8'hB0, 8'h5A);
    send(8'h70, 8'hFF);
    send(8'h08, 8'h80);
    send(8'h18, 8'hFF);
    send(8'h58, 8'h12);

    // R8: raw mode on / off
    send(8'h40, 8'h10);
    send(8'h40, 8'h11);
    send(8'h40, 8'h10);

    // random mix, R11 unknown opcodes included
    for (int n = 0; n < 400; n++) begin
      int idx;
      idx = $urandom_range(0, 16);
      d = 8'($urandom);
      if (idx == 16) begin
        c = 8'($urandom);
        if (is_prog(c) || c == 8'h00 || c == 8'h40 || c == 8'h50) c = 8'h01;
      end else begin
        c = ops[idx];
        if (c == 8'h40 && d[0]) d = 8'h10;
      end
      send(c, d);
    end

    // R10: read-out with stall and a foreign pair
    read_out(1'b1);
    read_out(1'b0);

    // R9: non-locking code, then code 011
    send(8'h58, 8'h17);
    send(8'hC0, 8'h11);
    send(8'h58, 8'h1D);
    send(8'hC0, 8'h22);
    send(8'h58, 8'h07);
    send(8'h28, 8'h99);
    send(8'h40, 8'h00);
    read_out(1'b0);

    // R1 R9: reset clears lock, then code 110
    do_reset();
    send(8'h50, 8'h90);
    send(8'h58, 8'h37);
    send(8'h90, 8'h01);
    send(8'h08, 8'h00);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule